// File: doc/BRIEF.md
# Keyboard Scan Code Prefix Decoder

This block sits behind a keyboard serial receiver and turns its stream of 8-bit scan codes into key event records. Each incoming byte arrives with a one-cycle valid strobe. The two prefix bytes, 0xE0 (extended key) and 0xF0 (key release), are absorbed and do not produce a record. They are remembered as pending flags and attached to the next ordinary byte. The block also follows the held state of the two shift keys and uses it to pick upper or lower case when it maps a key to ASCII.

Each record holds the scan code, the extended flag, the released flag, the shift-held state and an ASCII character. The record stays in an output register with `rec_ready` high until the consumer pulses `rd_ack`. A parameter selects whether shift key events make records of their own or are trapped, in which case they only update the `shift_key_on` status output.

Top module: `kbd_prefix_decoder`

## Requirements
- R1: A synchronous reset clears `rec_ready`, `shift_key_on`, both pending prefix flags and the record fields, so a key after reset carries clear flags.
- R2: A valid byte that is not a prefix (and is not trapped) loads a record with `rec_code` equal to the byte and raises `rec_ready` in the cycle after the strobe.
- R3: A valid 0xE0 produces no record. It sets a pending extended flag that appears as `rec_ext`=1 on the next record.
- R4: A valid 0xF0 produces no record. It sets a pending released flag that appears as `rec_rel`=1 on the next record.
- R5: Both pending flags are cleared by every non-prefix byte, including a trapped shift byte, so they apply to one key only.
- R6: The non-extended codes 0x12 (left shift) and 0x59 (right shift) set their own held bit on make and clear it when released. `shift_key_on` and `rec_shift` are the OR of the two bits, and `rec_shift` includes the event being recorded.
- R7: Letter keys map to ASCII lowercase 'a'..'z' when shift is not held and to uppercase 'A'..'Z' when it is held.
- R8: Digit keys map to '0'..'9' whatever the shift state. 0x29 maps to 0x20, 0x5A to 0x0D and 0x0D to 0x09. Shift codes, extended keys and unmapped codes give 0x00.
- R9: `rec_ready` and the record hold until `rd_ack`. A `rd_ack` while `rec_ready` is low has no effect. A new event in the same cycle as `rd_ack` wins and leaves `rec_ready` high.
- R10: A new event that arrives while `rec_ready` is high overwrites the record.
- R11: With `SHIFT_TRAP_EN`=1, shift make and release events leave `rec_ready` and the record unchanged and only update `shift_key_on`.
- R12: An extended-prefixed 0x12 or 0x59 is treated as an ordinary key and does not change the shift state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | One-cycle strobe marking a received scan code |
| code_byte | input | 8 | Received scan code |
| rd_ack | input | 1 | One-cycle pulse: the consumer has taken the record |
| rec_ready | output | 1 | A record is waiting |
| rec_code | output | 8 | Scan code of the record |
| rec_ext | output | 1 | Extended prefix preceded the key |
| rec_rel | output | 1 | Release prefix preceded the key |
| rec_shift | output | 1 | Shift held, including this event |
| rec_ascii | output | 8 | ASCII character, or 0x00 when none |
| shift_key_on | output | 1 | Current shift-held status |

## Verification
The assertions check on every cycle that a prefix byte never raises `rec_ready`, that an ordinary byte is recorded in the next cycle, that the record holds until it is acknowledged, that an acknowledge clears it, and that a prefix directly in front of a key shows up in the record. Flags that stay pending across idle gaps, the shift bookkeeping across overlapping left and right presses, the ASCII case selection and the trapping variant all depend on history over many cycles. Only the bench's scenarios show these, and it runs one instance of each variant against a reference model.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

   localparam int KPD_CODE_W = 8;

   typedef struct packed {
      logic [KPD_CODE_W-1:0] code;
      logic                  ext;
      logic                  rel;
      logic                  shift;
      logic [7:0]            ascii;
   } kpd_rec_t;

endpackage

// File: rtl/kpd_classify.sv
module kpd_classify #(
   parameter int                      CODE_W      = 8,
   parameter logic [CODE_W-1:0]       EXT_CODE    = 8'hE0,
   parameter logic [CODE_W-1:0]       REL_CODE    = 8'hF0,
   parameter int                      NUM_SHIFT   = 2,
   parameter logic [NUM_SHIFT*CODE_W-1:0] SHIFT_CODES = {8'h59, 8'h12}
) (
   input  logic                 valid,
   input  logic [CODE_W-1:0]    byte_in,
   input  logic                 pend_ext,
   output logic                 ext_pfx,
   output logic                 rel_pfx,
   output logic                 key_evt,
   output logic [NUM_SHIFT-1:0] shift_hit
);

   assign ext_pfx = valid && (byte_in == EXT_CODE);
   assign rel_pfx = valid && (byte_in == REL_CODE);
   assign key_evt = valid && !ext_pfx && !rel_pfx;

   for (genvar k = 0; k < NUM_SHIFT; k++) begin : g_hit
      assign shift_hit[k] = key_evt && !pend_ext &&
                            (byte_in == SHIFT_CODES[k*CODE_W +: CODE_W]);
   end

endmodule

// File: rtl/kpd_prefix_track.sv
module kpd_prefix_track (
   input  logic clk,
   input  logic rst,
   input  logic set_ext,
   input  logic set_rel,
   input  logic consume,
   output logic pend_ext,
   output logic pend_rel
);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_ext <= 1'b0;
         pend_rel <= 1'b0;
      end else if (consume) begin
         pend_ext <= 1'b0;
         pend_rel <= 1'b0;
      end else begin
         if (set_ext) pend_ext <= 1'b1;
         if (set_rel) pend_rel <= 1'b1;
      end
   end

endmodule

// File: rtl/kpd_shift_track.sv
module kpd_shift_track #(
   parameter int NUM_SHIFT = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_SHIFT-1:0] hit,
   input  logic                 release_evt,
   output logic                 held,
   output logic                 held_next
);

   logic [NUM_SHIFT-1:0] key_q;
   logic [NUM_SHIFT-1:0] key_d;

   for (genvar k = 0; k < NUM_SHIFT; k++) begin : g_key
      assign key_d[k] = hit[k] ? !release_evt : key_q[k];
      always_ff @(posedge clk) begin
         if (rst) key_q[k] <= 1'b0;
         else     key_q[k] <= key_d[k];
      end
   end

   assign held      = |key_q;
   assign held_next = |key_d;

endmodule

// File: rtl/kpd_ascii_map.sv
module kpd_ascii_map (
   input  logic [7:0] code,
   input  logic       upper,
   input  logic       blank,
   output logic [7:0] ascii
);

   localparam logic [4:0] NO_LETTER = 5'd31;
   localparam logic [3:0] NO_DIGIT  = 4'd15;

   logic [4:0] lidx;
   logic [3:0] didx;

   always_comb begin
      lidx = NO_LETTER;
      case (code)
         8'h1C: lidx = 5'd0;   8'h32: lidx = 5'd1;   8'h21: lidx = 5'd2;
         8'h23: lidx = 5'd3;   8'h24: lidx = 5'd4;   8'h2B: lidx = 5'd5;
         8'h34: lidx = 5'd6;   8'h33: lidx = 5'd7;   8'h43: lidx = 5'd8;
         8'h3B: lidx = 5'd9;   8'h42: lidx = 5'd10;  8'h4B: lidx = 5'd11;
         8'h3A: lidx = 5'd12;  8'h31: lidx = 5'd13;  8'h44: lidx = 5'd14;
         8'h4D: lidx = 5'd15;  8'h15: lidx = 5'd16;  8'h2D: lidx = 5'd17;
         8'h1B: lidx = 5'd18;  8'h2C: lidx = 5'd19;  8'h3C: lidx = 5'd20;
         8'h2A: lidx = 5'd21;  8'h1D: lidx = 5'd22;  8'h22: lidx = 5'd23;
         8'h35: lidx = 5'd24;  8'h1A: lidx = 5'd25;
         default: lidx = NO_LETTER;
      endcase
   end

   always_comb begin
      didx = NO_DIGIT;
      case (code)
         8'h45: didx = 4'd0;  8'h16: didx = 4'd1;  8'h1E: didx = 4'd2;
         8'h26: didx = 4'd3;  8'h25: didx = 4'd4;  8'h2E: didx = 4'd5;
         8'h36: didx = 4'd6;  8'h3D: didx = 4'd7;  8'h3E: didx = 4'd8;
         8'h46: didx = 4'd9;
         default: didx = NO_DIGIT;
      endcase
   end

   always_comb begin
      if (blank) begin
         ascii = 8'h00;
      end else if (lidx != NO_LETTER) begin
         ascii = (upper ? 8'h41 : 8'h61) + {3'b000, lidx};
      end else if (didx != NO_DIGIT) begin
         ascii = 8'h30 + {4'b0000, didx};
      end else begin
         case (code)
            8'h29:   ascii = 8'h20;
            8'h5A:   ascii = 8'h0D;
            8'h0D:   ascii = 8'h09;
            default: ascii = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/kpd_out_reg.sv
module kpd_out_reg
   import kpd_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     load,
   input  kpd_rec_t rec_in,
   input  logic     ack,
   output logic     ready,
   output kpd_rec_t rec_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         ready <= 1'b0;
         rec_q <= '0;
      end else if (load) begin
         ready <= 1'b1;
         rec_q <= rec_in;
      end else if (ack) begin
         ready <= 1'b0;
      end
   end

endmodule

// File: rtl/kbd_prefix_decoder.sv
module kbd_prefix_decoder
   import kpd_pkg::*;
#(
   parameter int                          CODE_W        = 8,
   parameter bit                          SHIFT_TRAP_EN = 1'b0,
   parameter logic [CODE_W-1:0]           EXT_CODE      = 8'hE0,
   parameter logic [CODE_W-1:0]           REL_CODE      = 8'hF0,
   parameter int                          NUM_SHIFT     = 2,
   parameter logic [NUM_SHIFT*CODE_W-1:0] SHIFT_CODES   = {8'h59, 8'h12}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              code_valid,
   input  logic [CODE_W-1:0] code_byte,
   input  logic              rd_ack,
   output logic              rec_ready,
   output logic [CODE_W-1:0] rec_code,
   output logic              rec_ext,
   output logic              rec_rel,
   output logic              rec_shift,
   output logic [7:0]        rec_ascii,
   output logic              shift_key_on
);

   if (CODE_W != KPD_CODE_W) begin : g_bad_width
      $error("kbd_prefix_decoder: CODE_W must equal the package code width");
   end
   if (NUM_SHIFT < 1) begin : g_bad_shift
      $error("kbd_prefix_decoder: NUM_SHIFT must be at least 1");
   end
   if (EXT_CODE == REL_CODE) begin : g_bad_prefix
      $error("kbd_prefix_decoder: prefix codes must differ");
   end

   logic                 ext_pfx, rel_pfx, key_evt;
   logic [NUM_SHIFT-1:0] shift_hit;
   logic                 pend_ext, pend_rel;
   logic                 held, held_next;
   logic                 shift_evt;
   logic                 emit;
   logic [7:0]           ascii_c;
   kpd_rec_t             rec_in, rec_q;

   kpd_classify #(
      .CODE_W     (CODE_W),
      .EXT_CODE   (EXT_CODE),
      .REL_CODE   (REL_CODE),
      .NUM_SHIFT  (NUM_SHIFT),
      .SHIFT_CODES(SHIFT_CODES)
   ) u_classify (
      .valid    (code_valid),
      .byte_in  (code_byte),
      .pend_ext (pend_ext),
      .ext_pfx  (ext_pfx),
      .rel_pfx  (rel_pfx),
      .key_evt  (key_evt),
      .shift_hit(shift_hit)
   );

   kpd_prefix_track u_prefix (
      .clk     (clk),
      .rst     (rst),
      .set_ext (ext_pfx),
      .set_rel (rel_pfx),
      .consume (key_evt),
      .pend_ext(pend_ext),
      .pend_rel(pend_rel)
   );

   kpd_shift_track #(.NUM_SHIFT(NUM_SHIFT)) u_shift (
      .clk        (clk),
      .rst        (rst),
      .hit        (shift_hit),
      .release_evt(pend_rel),
      .held       (held),
      .held_next  (held_next)
   );

   assign shift_evt = |shift_hit;

   if (SHIFT_TRAP_EN) begin : g_trap
      assign emit = key_evt && !shift_evt;
   end else begin : g_pass
      assign emit = key_evt;
   end

   kpd_ascii_map u_ascii (
      .code (code_byte),
      .upper(held),
      .blank(pend_ext || shift_evt),
      .ascii(ascii_c)
   );

   always_comb begin
      rec_in.code  = code_byte;
      rec_in.ext   = pend_ext;
      rec_in.rel   = pend_rel;
      rec_in.shift = held_next;
      rec_in.ascii = ascii_c;
   end

   kpd_out_reg u_out (
      .clk   (clk),
      .rst   (rst),
      .load  (emit),
      .rec_in(rec_in),
      .ack   (rd_ack),
      .ready (rec_ready),
      .rec_q (rec_q)
   );

   assign rec_code     = rec_q.code;
   assign rec_ext      = rec_q.ext;
   assign rec_rel      = rec_q.rel;
   assign rec_shift    = rec_q.shift;
   assign rec_ascii    = rec_q.ascii;
   assign shift_key_on = held;

endmodule

// File: rtl/kpd_checker.sv
module kpd_checker #(
   parameter int                          CODE_W      = 8,
   parameter logic [CODE_W-1:0]           EXT_CODE    = 8'hE0,
   parameter logic [CODE_W-1:0]           REL_CODE    = 8'hF0,
   parameter int                          NUM_SHIFT   = 2,
   parameter logic [NUM_SHIFT*CODE_W-1:0] SHIFT_CODES = {8'h59, 8'h12}
) (
   input logic              clk,
   input logic              rst,
   input logic              code_valid,
   input logic [CODE_W-1:0] code_byte,
   input logic              rd_ack,
   input logic              rec_ready,
   input logic [CODE_W-1:0] rec_code,
   input logic              rec_ext,
   input logic              rec_rel,
   input logic              shift_key_on
);

   logic is_shift_code;
   logic plain_key;

   always_comb begin
      is_shift_code = 1'b0;
      for (int k = 0; k < NUM_SHIFT; k++) begin
         if (code_byte == SHIFT_CODES[k*CODE_W +: CODE_W]) is_shift_code = 1'b1;
      end
   end

   assign plain_key = code_valid && code_byte != EXT_CODE &&
                      code_byte != REL_CODE && !is_shift_code;

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> !rec_ready && !shift_key_on);

   assert_key_recorded_R2: assert property (@(posedge clk) disable iff (rst)
      plain_key |=> rec_ready && rec_code == $past(code_byte));

   assert_ext_silent_R3: assert property (@(posedge clk) disable iff (rst)
      code_valid && code_byte == EXT_CODE && !rec_ready |=> !rec_ready);

   assert_rel_silent_R4: assert property (@(posedge clk) disable iff (rst)
      code_valid && code_byte == REL_CODE && !rec_ready |=> !rec_ready);

   assert_ext_attached_R3: assert property (@(posedge clk) disable iff (rst)
      plain_key && $past(code_valid && code_byte == EXT_CODE) |=> rec_ext);

   assert_rel_attached_R4: assert property (@(posedge clk) disable iff (rst)
      plain_key && $past(code_valid && code_byte == REL_CODE) |=> rec_rel);

   assert_record_held_R9: assert property (@(posedge clk) disable iff (rst)
      rec_ready && !rd_ack && !code_valid |=> rec_ready && $stable(rec_code));

   assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
      rd_ack && !code_valid |=> !rec_ready);

endmodule

bind kbd_prefix_decoder kpd_checker #(
   .CODE_W     (CODE_W),
   .EXT_CODE   (EXT_CODE),
   .REL_CODE   (REL_CODE),
   .NUM_SHIFT  (NUM_SHIFT),
   .SHIFT_CODES(SHIFT_CODES)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .code_valid  (code_valid),
   .code_byte   (code_byte),
   .rd_ack      (rd_ack),
   .rec_ready   (rec_ready),
   .rec_code    (rec_code),
   .rec_ext     (rec_ext),
   .rec_rel     (rec_rel),
   .shift_key_on(shift_key_on)
);

// File: tb/kbd_prefix_decoder_tb.sv
module kbd_prefix_decoder_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       code_valid = 1'b0;
   logic [7:0] code_byte = 8'h00;
   logic       rd_ack = 1'b0;

   logic       rdy   [2];
   logic [7:0] code  [2];
   logic       ext   [2];
   logic       rel   [2];
   logic       shf   [2];
   logic [7:0] asc   [2];
   logic       skon  [2];

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   kbd_prefix_decoder #(.SHIFT_TRAP_EN(1'b0)) u_dut (
      .clk(clk), .rst(rst), .code_valid(code_valid), .code_byte(code_byte),
      .rd_ack(rd_ack), .rec_ready(rdy[0]), .rec_code(code[0]), .rec_ext(ext[0]),
      .rec_rel(rel[0]), .rec_shift(shf[0]), .rec_ascii(asc[0]),
      .shift_key_on(skon[0]));

   kbd_prefix_decoder #(.SHIFT_TRAP_EN(1'b1)) u_dut_trap (
      .clk(clk), .rst(rst), .code_valid(code_valid), .code_byte(code_byte),
      .rd_ack(rd_ack), .rec_ready(rdy[1]), .rec_code(code[1]), .rec_ext(ext[1]),
      .rec_rel(rel[1]), .rec_shift(shf[1]), .rec_ascii(asc[1]),
      .shift_key_on(skon[1]));

   localparam logic [7:0] LET [26] = '{
      8'h1C, 8'h32, 8'h21, 8'h23, 8'h24, 8'h2B, 8'h34, 8'h33, 8'h43, 8'h3B,
      8'h42, 8'h4B, 8'h3A, 8'h31, 8'h44, 8'h4D, 8'h15, 8'h2D, 8'h1B, 8'h2C,
      8'h3C, 8'h2A, 8'h1D, 8'h22, 8'h35, 8'h1A};
   localparam logic [7:0] DIG [10] = '{
      8'h45, 8'h16, 8'h1E, 8'h26, 8'h25, 8'h2E, 8'h36, 8'h3D, 8'h3E, 8'h46};

   // reference model state, index 0 = pass-through, 1 = trapping
   bit         m_pe [2], m_pr [2], m_ls [2], m_rs [2], m_rdy [2];
   logic [7:0] m_code [2], m_asc [2];
   bit         m_ext [2], m_rel [2], m_shf [2];

   function automatic logic [7:0] ref_ascii(logic [7:0] b, bit upper);
      for (int i = 0; i < 26; i++)
         if (LET[i] == b) return (upper ? 8'h41 : 8'h61) + 8'(i);
      for (int i = 0; i < 10; i++)
         if (DIG[i] == b) return 8'h30 + 8'(i);
      if (b == 8'h29) return 8'h20;
      if (b == 8'h5A) return 8'h0D;
      if (b == 8'h0D) return 8'h09;
      return 8'h00;
   endfunction

   function automatic void model_reset();
      for (int d = 0; d < 2; d++) begin
         m_pe[d] = 0; m_pr[d] = 0; m_ls[d] = 0; m_rs[d] = 0; m_rdy[d] = 0;
         m_code[d] = 0; m_asc[d] = 0; m_ext[d] = 0; m_rel[d] = 0; m_shf[d] = 0;
      end
   endfunction

   function automatic void model_step(bit v, logic [7:0] b, bit ack);
      for (int d = 0; d < 2; d++) begin
         bit sk, up, emit;
         if (v && b == 8'hE0) begin
            m_pe[d] = 1;
            if (ack) m_rdy[d] = 0;
         end else if (v && b == 8'hF0) begin
            m_pr[d] = 1;
            if (ack) m_rdy[d] = 0;
         end else if (v) begin
            sk = !m_pe[d] && (b == 8'h12 || b == 8'h59);
            up = m_ls[d] | m_rs[d];
            if (sk && b == 8'h12) m_ls[d] = !m_pr[d];
            if (sk && b == 8'h59) m_rs[d] = !m_pr[d];
            emit = !(d == 1 && sk);
            if (emit) begin
               m_rdy[d]  = 1;
               m_code[d] = b;
               m_ext[d]  = m_pe[d];
               m_rel[d]  = m_pr[d];
               m_shf[d]  = m_ls[d] | m_rs[d];
               m_asc[d]  = (m_pe[d] || sk) ? 8'h00 : ref_ascii(b, up);
            end else if (ack) begin
               m_rdy[d] = 0;
            end
            m_pe[d] = 0;
            m_pr[d] = 0;
         end else if (ack) begin
            m_rdy[d] = 0;
         end
      end
   endfunction

   task automatic compare(string tag);
      for (int d = 0; d < 2; d++) begin
         bit bad;
         n_checks++;
         bad = (rdy[d] !== m_rdy[d]) || (skon[d] !== (m_ls[d] | m_rs[d]));
         if (m_rdy[d])
            bad = bad || code[d] !== m_code[d] || ext[d] !== m_ext[d] ||
                  rel[d] !== m_rel[d] || shf[d] !== m_shf[d] || asc[d] !== m_asc[d];
         if (bad) begin
            n_fail++;
            $display("FAIL %s dut%0d: got rdy=%b code=%h ext=%b rel=%b sh=%b asc=%h on=%b exp rdy=%b code=%h ext=%b rel=%b sh=%b asc=%h on=%b",
                     tag, d, rdy[d], code[d], ext[d], rel[d], shf[d], asc[d], skon[d],
                     m_rdy[d], m_code[d], m_ext[d], m_rel[d], m_shf[d], m_asc[d],
                     m_ls[d] | m_rs[d]);
         end
      end
   endtask

   task automatic step(bit v, logic [7:0] b, bit ack, string tag);
      @(negedge clk);
      code_valid = v;
      code_byte  = b;
      rd_ack     = ack;
      model_step(v, b, ack);
      @(posedge clk);
      #5;
      compare(tag);
   endtask

   task automatic key(logic [7:0] b, string tag);
      step(1'b1, b, 1'b0, tag);
   endtask

   task automatic do_reset(string tag);
      @(negedge clk);
      rst = 1'b1; code_valid = 1'b0; rd_ack = 1'b0;
      model_reset();
      @(posedge clk);
      #5;
      @(negedge clk);
      rst = 1'b0;
      #1;
      compare(tag);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      do_reset("R1");
      step(1'b0, 8'h00, 1'b0, "R1");

      key(8'h1C, "R2 R7");                      // 'a'
      step(1'b0, 8'h00, 1'b1, "R9");            // ack clears
      step(1'b0, 8'h00, 1'b1, "R9");            // ack while idle: no effect
      key(8'hE0, "R3");
      step(1'b0, 8'h00, 1'b0, "R3");            // pending survives a gap
      key(8'h75, "R3 R8");                      // extended key, ascii 0
      key(8'hF0, "R4");
      key(8'h1C, "R4");
      key(8'h32, "R5");                         // flags gone
      key(8'h12, "R6 R11");                     // left shift make
      key(8'h1C, "R7");                         // 'A'
      key(8'h59, "R6 R11");                     // right make
      key(8'hF0, "R6");
      key(8'h12, "R6");                         // left break, right held
      key(8'h21, "R6 R7");                      // 'C'
      key(8'hF0, "R6");
      key(8'h59, "R6 R11");                     // right break
      key(8'h21, "R7");                         // 'c'
      key(8'hE0, "R12");
      key(8'h12, "R12");                        // extended 0x12: not shift
      key(8'h0D, "R8");                         // tab
      key(8'h5A, "R8");                         // enter
      key(8'h29, "R8");                         // space
      key(8'h16, "R8");                         // '1'
      key(8'h07, "R8");                         // unmapped
      key(8'h24, "R10");                        // overwrite while ready
      step(1'b1, 8'h2B, 1'b1, "R9");            // event wins over ack
      key(8'hE0, "R11 R5");
      key(8'hF0, "R11 R5");
      key(8'h1A, "R5");
      key(8'hF0, "R11");
      key(8'h12, "R11 R5");                     // trapped break clears flags
      key(8'h1C, "R5 R11");
      key(8'hE0, "R1");
      do_reset("R1");
      key(8'h1C, "R1");                         // flags cleared by reset

      for (int i = 0; i < 4000; i++) begin
         int sel;
         bit v, a;
         logic [7:0] b;
         v   = ($urandom % 100) < 60;
         a   = ($urandom % 100) < 25;
         sel = $urandom % 10;
         case (sel)
            0:       b = 8'hE0;
            1:       b = 8'hF0;
            2:       b = 8'h12;
            3:       b = 8'h59;
            4, 5:    b = LET[$urandom % 26];
            6:       b = DIG[$urandom % 10];
            default: b = 8'($urandom);
         endcase
         step(v, b, a, "R2");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule